// File: doc/BRIEF.md
# RTC Interrupt Status Register with Read-to-Clear

This block holds the interrupt state of a real-time clock that has two interrupt sources: a daily alarm match and the end of each once-per-second update. Each source has a sticky flag and a software-written enable. A summary bit is high while any source has both its flag and its enable set, and it also drives an active-high interrupt request pin. A flag is set by its event whether or not the source is enabled, so software can poll a flag as plain status. Software can also take interrupts on it.

Software reads the status byte by raising a read strobe, which may stay high for several cycles. A small sequencer with two states, `RS_IDLE` and `RS_HOLD`, controls the read. The transition `CAPTURE` (`RS_IDLE` to `RS_HOLD`, taken on the first clock edge at which the strobe is high) latches a snapshot of the flags and the summary bit. The read data shows that snapshot, unchanged, for as long as the strobe stays high. The transition `RELEASE` (`RS_HOLD` to `RS_IDLE`, taken on the first edge at which the strobe is low again) clears the flags that were returned.

While the strobe is high, events are not lost and are not shown in the snapshot. They are parked in a pending bit and posted to the flag at `RELEASE`. A staying transition `HOLD` keeps the sequencer in `RS_HOLD` while the strobe remains high, and `WAIT` keeps it in `RS_IDLE` while the strobe is low.

Top module: `rtc_irq_status`

## Requirements
- R1: After reset both flags and both enables are 0, `irq_o` is low and `rd_data_o` is 0.
- R2: An alarm or update event outside a read sets its own flag on that clock edge, whatever the state of its enable.
- R3: `irq_o` is high exactly when (alarm flag AND alarm enable) OR (update flag AND update enable). If a flag is already set, writing its enable to 1 raises `irq_o` on the write edge.
- R4: During a read, `rd_data_o` bit 7 is the summary bit, bit 5 is the alarm flag and bit 4 is the update flag, all sampled at the CAPTURE edge. Every other bit is 0. Outside a read, `rd_data_o` is all zero.
- R5: The snapshot stays constant for every cycle that the read strobe stays high.
- R6: At RELEASE, every flag returned as 1 is cleared, and the summary bit and `irq_o` drop unless a deferred event is posted.
- R7: An event that arrives on the CAPTURE edge or on any later edge while the strobe is high is absent from the snapshot and sets its flag at RELEASE.
- R8: An event that arrives on the RELEASE edge itself sets its flag.
- R9: When both flags are set they are returned together in one read and both are cleared by it.
- R10: An enable write takes the alarm enable from data bit 5 and the update enable from data bit 4. All other data bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_evt_i | input | 1 | One-cycle pulse when the alarm time matches |
| update_evt_i | input | 1 | One-cycle pulse when an update cycle ends |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 8 | Enable write data (bit 5 alarm, bit 4 update) |
| rd_strobe_i | input | 1 | Status read strobe; may be held high for several cycles |
| rd_data_o | output | 8 | Status snapshot while a read is in progress, else 0 |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The embedded assertions are checked on every cycle. They cover the following:
- A flag rises after an event that arrives outside a read window.
- Flags and read data stay frozen while the strobe is held.
- An event inside the window is parked as pending and posted at release.
- A returned flag is cleared at release when nothing is pending.
- A captured summary bit always comes with at least one captured source flag.

Only the bench scenarios can show the end-to-end results. These include the exact byte returned for every enable and flag combination, and the rise of `irq_o` when an enable is written over a flag that is already set. They also include the correct split between the snapshot and the flags that remain for events landing on the capture, hold and release edges, and the ignored enable bits.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_HOLD = 1'b1
    } rd_state_e;

    localparam int unsigned NSRC    = 2;
    localparam int unsigned SRC_UPD = 0;
    localparam int unsigned SRC_ALM = 1;

endpackage

// File: rtl/rtc_irq_rdseq.sv
module rtc_irq_rdseq
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe_i,
    output logic capture_o,
    output logic release_o,
    output logic defer_o,
    output logic hold_o
);

    rd_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Next state and decoded strobes
    always_comb begin
        state_d   = state_q;
        capture_o = 1'b0;
        release_o = 1'b0;
        defer_o   = 1'b0;
        hold_o    = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                if (rd_strobe_i) begin        // CAPTURE
                    state_d   = RS_HOLD;
                    capture_o = 1'b1;
                    defer_o   = 1'b1;
                end                           // else WAIT
            end
            RS_HOLD: begin
                hold_o = 1'b1;
                if (rd_strobe_i) begin        // HOLD
                    defer_o = 1'b1;
                end else begin                // RELEASE
                    state_d   = RS_IDLE;
                    release_o = 1'b1;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    assert_release_after_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !hold_o);
    assert_capture_enters_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |=> hold_o);

endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic defer_i,
    input  logic release_i,
    input  logic snap_bit_i,
    output logic flag_o
);

    logic flag_q, pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (release_i) begin
            flag_q <= (flag_q & ~snap_bit_i) | pend_q | evt_i;
            pend_q <= 1'b0;
        end else if (defer_i) begin
            pend_q <= pend_q | evt_i;
        end else if (evt_i) begin
            flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    assert_evt_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !defer_i) |=> flag_q);
    assert_flag_frozen_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        defer_i |=> $stable(flag_q));
    assert_evt_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (defer_i && evt_i) |=> pend_q);
    assert_pend_posted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && pend_q) |=> (flag_q && !pend_q));
    assert_returned_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && snap_bit_i && !pend_q && !evt_i) |=> !flag_q);

endmodule

// File: rtl/rtc_irq_enreg.sv
module rtc_irq_enreg #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NSRC    = 2,
    parameter int unsigned POS_UPD = 4,
    parameter int unsigned POS_ALM = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NSRC-1:0]   en_o
);

    localparam int unsigned POS [2] = '{POS_UPD, POS_ALM};

    for (genvar g = 0; g < NSRC; g++) begin : g_en
        logic en_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    en_q <= 1'b0;
            else if (wr_i) en_q <= wdata_i[POS[g]];
        end
        assign en_o[g] = en_q;
    end

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
    import rtc_irq_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned IRQF_POS = 7,
    parameter int unsigned ALM_POS  = 5,
    parameter int unsigned UPD_POS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_evt_i,
    input  logic              update_evt_i,
    input  logic              en_wr_i,
    input  logic [DATA_W-1:0] en_wdata_i,
    input  logic              rd_strobe_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);

    localparam int unsigned SRC_POS [NSRC] = '{UPD_POS, ALM_POS};

    logic            capture, release_s, defer, hold;
    logic [NSRC-1:0] evt, flag, en, snap_src;
    logic            snap_irqf;

    assign evt[SRC_UPD] = update_evt_i;
    assign evt[SRC_ALM] = alarm_evt_i;

    rtc_irq_rdseq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_strobe_i(rd_strobe_i),
        .capture_o  (capture),
        .release_o  (release_s),
        .defer_o    (defer),
        .hold_o     (hold)
    );

    rtc_irq_enreg #(
        .DATA_W (DATA_W),
        .NSRC   (NSRC),
        .POS_UPD(UPD_POS),
        .POS_ALM(ALM_POS)
    ) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (en_wr_i),
        .wdata_i(en_wdata_i),
        .en_o   (en)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        rtc_irq_flag u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt[g]),
            .defer_i   (defer),
            .release_i (release_s),
            .snap_bit_i(snap_src[g]),
            .flag_o    (flag[g])
        );
    end

    // Snapshot latch, loaded only on CAPTURE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_src  <= '0;
            snap_irqf <= 1'b0;
        end else if (capture) begin
            snap_src  <= flag;
            snap_irqf <= |(flag & en);
        end
    end

    // Read data and interrupt outputs
    always_comb begin
        rd_data_o = '0;
        if (hold) begin
            rd_data_o[IRQF_POS] = snap_irqf;
            for (int i = 0; i < NSRC; i++) rd_data_o[SRC_POS[i]] = snap_src[i];
        end
    end

    assign irq_o = |(flag & en);

    assert_snapshot_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && rd_strobe_i) |=> $stable(rd_data_o));
    assert_irqf_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[IRQF_POS] |-> (rd_data_o[ALM_POS] || rd_data_o[UPD_POS]));
    assert_idle_data_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (rd_data_o == '0));

endmodule

// File: tb/rtc_irq_status_tb_top.sv
module rtc_irq_status_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alarm_evt_i = 1'b0, update_evt_i = 1'b0;
    logic       en_wr_i = 1'b0, rd_strobe_i = 1'b0;
    logic [7:0] en_wdata_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int n_vec = 0, n_bad = 0;
    logic e_af = 0, e_uf = 0, e_aie = 0, e_uie = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_status dut_i (
        .clk(clk), .rst_n(rst_n), .alarm_evt_i(alarm_evt_i), .update_evt_i(update_evt_i),
        .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .rd_strobe_i(rd_strobe_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic e_irq();
        return (e_af & e_aie) | (e_uf & e_uie);
    endfunction

    function automatic logic [7:0] e_byte();
        return {e_irq(), 1'b0, e_af, e_uf, 4'b0};
    endfunction

    task automatic wr_en(logic [7:0] d);
        en_wr_i = 1; en_wdata_i = d; step(); en_wr_i = 0;
        e_aie = d[5]; e_uie = d[4];
    endtask

    task automatic pulse(logic a, logic u);
        alarm_evt_i = a; update_evt_i = u; step();
        alarm_evt_i = 0; update_evt_i = 0;
        e_af |= a; e_uf |= u;
    endtask

    // Full read with a strobe held for len cycles; checks snapshot each cycle
    task automatic do_read(int len, string req);
        logic [7:0] exp;
        exp = e_byte();
        rd_strobe_i = 1;
        for (int k = 0; k < len; k++) begin
            step();
            chk(req, rd_data_o, exp);
        end
        rd_strobe_i = 0; step();
        if (exp[5]) e_af = 0;
        if (exp[4]) e_uf = 0;
        chk("R4 idle zero", rd_data_o, 8'h00);
        chk("R6 irq after release", {7'b0, irq_o}, {7'b0, e_irq()});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        chk("R1 irq reset", {7'b0, irq_o}, 8'h00);
        chk("R1 data reset", rd_data_o, 8'h00);
        rst_n = 1; step();
        do_read(1, "R1 flags reset");

        // R2 R3 R4 R9: sweep enables x flags x strobe lengths
        for (int en = 0; en < 4; en++) begin
            for (int fl = 0; fl < 4; fl++) begin
                for (int len = 1; len < 4; len++) begin
                    wr_en({2'b0, en[1], en[0], 4'b0});
                    pulse(fl[1], fl[0]);
                    chk("R2 R3 irq level", {7'b0, irq_o}, {7'b0, e_irq()});
                    do_read(len, "R4 R5 R9 snapshot");
                    do_read(1, "R6 cleared");
                end
            end
        end

        // R3: enable written over a flag that is already set
        wr_en(8'h00);
        pulse(1, 0);
        chk("R3 irq disabled", {7'b0, irq_o}, 8'h00);
        wr_en(8'h20);
        chk("R3 immediate irq", {7'b0, irq_o}, 8'h01);
        do_read(2, "R3 snapshot");

        // R10: other data bits ignored
        wr_en(8'hCF);
        pulse(1, 1);
        chk("R10 ignored bits", {7'b0, irq_o}, 8'h00);
        do_read(1, "R10 snapshot");
        wr_en(8'h10);
        pulse(0, 1);
        chk("R10 update enable", {7'b0, irq_o}, 8'h01);
        do_read(1, "R10 snapshot2");

        // R7 R8: events at capture, mid-hold and release edges
        wr_en(8'h30);
        for (int ph = 0; ph < 3; ph++) begin
            for (int src = 0; src < 2; src++) begin
                logic [7:0] snap_exp;
                logic a, u;
                a = (src == 1); u = (src == 0);
                pulse(~a, ~u);            // other source pre-set
                snap_exp = e_byte();
                rd_strobe_i = 1;
                if (ph == 0) begin alarm_evt_i = a; update_evt_i = u; end
                step(); alarm_evt_i = 0; update_evt_i = 0;
                chk("R7 capture excl", rd_data_o, snap_exp);
                if (ph == 1) begin alarm_evt_i = a; update_evt_i = u; end
                step(); alarm_evt_i = 0; update_evt_i = 0;
                chk("R5 R7 hold excl", rd_data_o, snap_exp);
                rd_strobe_i = 0;
                if (ph == 2) begin alarm_evt_i = a; update_evt_i = u; end
                step(); alarm_evt_i = 0; update_evt_i = 0;
                e_af = a; e_uf = u;
                chk(ph == 2 ? "R8 release evt irq" : "R7 posted irq",
                    {7'b0, irq_o}, 8'h01);
                do_read(1, ph == 2 ? "R8 flag kept" : "R7 flag posted");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule